// File: doc/BRIEF.md
# Dual-Lane Shift-Mask-Add Interpolator

A register-mapped arithmetic helper that holds two 32-bit accumulators, three 32-bit base registers and two lane control words. Each lane takes an accumulator, shifts it right, keeps a chosen bit range, optionally sign-extends that range and adds a base to it, which gives a lane result. A third result adds the processed values of both lanes to the third base. Software walks tables or steps fixed-point coordinates by reading results and letting the block write them back.

Access goes through one synchronous request port that carries one read or one write per cycle. A read of a "peek" address returns a result and changes nothing. A read of a "pop" address returns the same result and, at the same clock edge, loads both accumulators from the lane results. Dedicated write addresses add to an accumulator in one step, or load two bases at once from the two halves of a word.

Top module: `interp_top`

## Requirements
- R1: After reset every register is zero, `rd_data` is zero, and a read of any of the 16 addresses returns zero.
- R2: Address map (`req_addr`): 0 acc0, 1 acc1, 2 base0, 3 base1, 4 base2, 5 pop0, 6 pop1, 7 pop2, 8 peek0, 9 peek1, 10 peek2, 11 ctrl0, 12 ctrl1, 13 add0, 14 add1, 15 base-pair. A write to 0..4 stores the word. A read (`req_en`=1, `req_we`=0) puts its value on `rd_data` after the next rising edge. `rd_data` holds when no read is issued. Reads of 13, 14 and 15 return zero.
- R3: Control word fields: SHIFT [4:0], LSB [9:5], MSB [14:10]. The lane shifts its source logically right by SHIFT, then clears every bit outside LSB..MSB inclusive. If MSB < LSB, the mask is empty.
- R4: With bit 15 set, the bit at position MSB of the masked value is copied into all bits above MSB.
- R5: With bit 16 set, the lane uses the other lane's accumulator as its source.
- R6: With bit 18 set, the lane result is the base plus the unshifted, unmasked source. Otherwise it is the base plus the processed value.
- R7: Bits [20:19] are ORed into bits [29:28] of the lane result returned by a pop or peek read. They are not written back to an accumulator.
- R8: Result 2 equals base2 plus the processed values (R3, R4) of both lanes. It ignores bit 18 and bits [20:19].
- R9: A pop read loads each accumulator with its own lane's result, or with the other lane's result when that lane's bit 17 is set. Both loads happen at the edge that captures the read, and both use the values held before that edge.
- R10: A peek read changes no accumulator, base or control register.
- R11: A write to add0 or add1 adds the zero-extended wdata[23:0] to that accumulator, modulo 2^32.
- R12: A write to the base-pair address loads zero-extended wdata[15:0] into base0 and zero-extended wdata[31:16] into base1 in the same cycle. base2 keeps its value.
- R13: Control bits above bit 20 are not stored. A read of ctrl0 shows bit 23 set when lane 0's shifted source has a nonzero bit above MSB, bit 24 set when the same holds for lane 1, and bit 25 set when either of them is set. A read of ctrl1 shows none of these flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_en | input | 1 | Request valid this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |

## Verification
Every read result appears on `rd_data` exactly one edge after the request. The bench drives each request on a falling edge, removes it on the next falling edge, and samples `rd_data` at that falling edge. Register side effects of a write or pop land at the same edge, so the next read sees them. To observe them, the bench reads the accumulators and bases back through the port, and reads results again with peeks. The bench confirms that `rd_data` holds during idle cycles, and that the state after a peek stays unchanged, by reading it back.

// File: rtl/interp_pkg.sv
package interp_pkg;
    localparam int XLEN      = 32;
    localparam int SHW       = $clog2(XLEN);
    localparam int ADD_W     = 24;
    localparam int HALF_W    = XLEN / 2;
    localparam int FORCE_LSB = 28;
    localparam int OVF0_POS  = 23;

    typedef struct packed {
        logic [1:0]     force_msb;
        logic           add_raw;
        logic           cross_res;
        logic           cross_in;
        logic           sgn;
        logic [SHW-1:0] msb;
        logic [SHW-1:0] lsb;
        logic [SHW-1:0] shift;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [3:0] {
        A_ACC0  = 4'd0,  A_ACC1  = 4'd1,  A_BASE0 = 4'd2,  A_BASE1 = 4'd3,
        A_BASE2 = 4'd4,  A_POP0  = 4'd5,  A_POP1  = 4'd6,  A_POP2  = 4'd7,
        A_PEEK0 = 4'd8,  A_PEEK1 = 4'd9,  A_PEEK2 = 4'd10, A_CTRL0 = 4'd11,
        A_CTRL1 = 4'd12, A_ADD0  = 4'd13, A_ADD1  = 4'd14, A_BPAIR = 4'd15
    } addr_e;
endpackage

// File: rtl/interp_lane.sv
module interp_lane
    import interp_pkg::*;
(
    input  logic [XLEN-1:0] acc_own,
    input  logic [XLEN-1:0] acc_other,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] other_wb,
    input  ctrl_t           ctrl,
    output logic [XLEN-1:0] proc,
    output logic [XLEN-1:0] res_wb,
    output logic [XLEN-1:0] res_rd,
    output logic [XLEN-1:0] acc_next,
    output logic            ovf
);
    logic [XLEN-1:0] src, shifted, mask_hi, mask_lo, mask, masked, ext;
    logic [SHW-1:0]  hi_sh;

    always_comb begin
        src     = ctrl.cross_in ? acc_other : acc_own;
        shifted = src >> ctrl.shift;
        hi_sh   = SHW'(XLEN - 1) - ctrl.msb;
        mask_hi = {XLEN{1'b1}} >> hi_sh;
        mask_lo = {XLEN{1'b1}} << ctrl.lsb;
        mask    = mask_hi & mask_lo;
        masked  = shifted & mask;
        ext     = (ctrl.sgn && masked[ctrl.msb]) ? ~mask_hi : '0;
        proc    = masked | ext;
        ovf     = |(shifted & ~mask_hi);
        res_wb  = base + (ctrl.add_raw ? src : proc);
        res_rd  = res_wb | ({{(XLEN-2){1'b0}}, ctrl.force_msb} << FORCE_LSB);
        acc_next = ctrl.cross_res ? other_wb : res_wb;
    end
endmodule

// File: rtl/interp_rdmux.sv
module interp_rdmux
    import interp_pkg::*;
(
    input  addr_e                 addr,
    input  logic [1:0][XLEN-1:0]  acc,
    input  logic [2:0][XLEN-1:0]  base,
    input  ctrl_t [1:0]           ctrl,
    input  logic [2:0][XLEN-1:0]  res_rd,
    input  logic [1:0]            ovf,
    output logic [XLEN-1:0]       rdata
);
    localparam int PAD0 = OVF0_POS - CTRL_W;
    localparam int TOPW = XLEN - OVF0_POS - 3;

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_ACC0:  rdata = acc[0];
            A_ACC1:  rdata = acc[1];
            A_BASE0: rdata = base[0];
            A_BASE1: rdata = base[1];
            A_BASE2: rdata = base[2];
            A_POP0, A_PEEK0: rdata = res_rd[0];
            A_POP1, A_PEEK1: rdata = res_rd[1];
            A_POP2, A_PEEK2: rdata = res_rd[2];
            A_CTRL0: rdata = {{TOPW{1'b0}}, |ovf, ovf[1], ovf[0], {PAD0{1'b0}}, ctrl[0]};
            A_CTRL1: rdata = {{(XLEN-CTRL_W){1'b0}}, ctrl[1]};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/interp_top.sv
module interp_top
    import interp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_en,
    input  logic             req_we,
    input  logic [3:0]       req_addr,
    input  logic [XLEN-1:0]  req_wdata,
    output logic [XLEN-1:0]  rd_data
);
    typedef struct packed {
        logic [1:0][XLEN-1:0] acc;
        logic [2:0][XLEN-1:0] base;
        ctrl_t [1:0]          ctrl;
        logic [XLEN-1:0]      rd;
    } state_t;

    state_t st_d, st_q;

    addr_e                addr;
    logic [1:0][XLEN-1:0] proc, acc_next;
    logic [2:0][XLEN-1:0] res_wb, res_rd;
    logic [1:0]           ovf;
    logic [XLEN-1:0]      rdata;
    logic                 is_rd, is_wr, is_pop;

    assign addr = addr_e'(req_addr);

    for (genvar i = 0; i < 2; i++) begin : g_lane
        interp_lane u_lane (
            .acc_own   (st_q.acc[i]),
            .acc_other (st_q.acc[1-i]),
            .base      (st_q.base[i]),
            .other_wb  (res_wb[1-i]),
            .ctrl      (st_q.ctrl[i]),
            .proc      (proc[i]),
            .res_wb    (res_wb[i]),
            .res_rd    (res_rd[i]),
            .acc_next  (acc_next[i]),
            .ovf       (ovf[i])
        );
    end

    assign res_wb[2] = st_q.base[2] + proc[0] + proc[1];
    assign res_rd[2] = res_wb[2];

    interp_rdmux u_rdmux (
        .addr   (addr),
        .acc    (st_q.acc),
        .base   (st_q.base),
        .ctrl   (st_q.ctrl),
        .res_rd (res_rd),
        .ovf    (ovf),
        .rdata  (rdata)
    );

    always_comb begin
        st_d   = st_q;
        is_rd  = req_en && !req_we;
        is_wr  = req_en && req_we;
        is_pop = is_rd && (addr == A_POP0 || addr == A_POP1 || addr == A_POP2);
        if (is_wr) begin
            case (addr)
                A_ACC0:  st_d.acc[0]  = req_wdata;
                A_ACC1:  st_d.acc[1]  = req_wdata;
                A_BASE0: st_d.base[0] = req_wdata;
                A_BASE1: st_d.base[1] = req_wdata;
                A_BASE2: st_d.base[2] = req_wdata;
                A_CTRL0: st_d.ctrl[0] = ctrl_t'(req_wdata[CTRL_W-1:0]);
                A_CTRL1: st_d.ctrl[1] = ctrl_t'(req_wdata[CTRL_W-1:0]);
                A_ADD0:  st_d.acc[0]  = st_q.acc[0] + {{(XLEN-ADD_W){1'b0}}, req_wdata[ADD_W-1:0]};
                A_ADD1:  st_d.acc[1]  = st_q.acc[1] + {{(XLEN-ADD_W){1'b0}}, req_wdata[ADD_W-1:0]};
                A_BPAIR: begin
                    st_d.base[0] = {{(XLEN-HALF_W){1'b0}}, req_wdata[HALF_W-1:0]};
                    st_d.base[1] = {{(XLEN-HALF_W){1'b0}}, req_wdata[XLEN-1:HALF_W]};
                end
                default: ;
            endcase
        end
        if (is_rd) st_d.rd = rdata;
        if (is_pop) st_d.acc = acc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd;

    // R2: read data holds while no read is requested
    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_en && !req_we) |=> $stable(rd_data));

    // R9: pop without cross routing loads each lane's own result
    p_pop_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pop && !st_q.ctrl[0].cross_res && !st_q.ctrl[1].cross_res)
        |=> (st_q.acc[0] == $past(res_wb[0])) && (st_q.acc[1] == $past(res_wb[1])));

    // R10: peek leaves all architectural registers untouched
    p_peek_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && !req_we && (addr == A_PEEK0 || addr == A_PEEK1 || addr == A_PEEK2))
        |=> $stable(st_q.acc) && $stable(st_q.base) && $stable(st_q.ctrl));

    // R11: atomic add on accumulator 0
    p_acc_add_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && req_we && addr == A_ADD0)
        |=> st_q.acc[0] == $past(st_q.acc[0]) + {{(XLEN-ADD_W){1'b0}}, $past(req_wdata[ADD_W-1:0])});

    // R12: split base write loads both halves, base2 untouched
    p_base_split_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && req_we && addr == A_BPAIR)
        |=> (st_q.base[0][HALF_W-1:0] == $past(req_wdata[HALF_W-1:0]))
            && (st_q.base[1][HALF_W-1:0] == $past(req_wdata[XLEN-1:HALF_W]))
            && (st_q.base[0][XLEN-1:HALF_W] == '0) && $stable(st_q.base[2]));

    // R13: summary flag on a ctrl0 read is the OR of the two lane flags
    p_ovf_or_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && !req_we && addr == A_CTRL0)
        |=> rd_data[OVF0_POS+2] == (rd_data[OVF0_POS] | rd_data[OVF0_POS+1]));
endmodule

// File: tb/interp_top_tb_top.sv
module interp_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_en = 1'b0;
    logic        req_we = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    interp_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data)
    );

    localparam logic [3:0] ACC0 = 0, ACC1 = 1, BASE0 = 2, BASE1 = 3, BASE2 = 4,
        POP0 = 5, POP1 = 6, POP2 = 7, PEEK0 = 8, PEEK1 = 9, PEEK2 = 10,
        CTRL0 = 11, CTRL1 = 12, ADD0 = 13, ADD1 = 14, BPAIR = 15;

    typedef struct packed {
        logic [31:0] c0, c1, a0, a1, b0, b1, b2, e0, e1, e2, ec0;
    } vec_t;

    localparam vec_t VECS [4] = '{
        // R3 shift/mask on both lanes, R13 flags both set
        '{32'h1C04, 32'h2C80, 32'h1234, 32'hABCD, 32'h100, 32'h10, 32'h1000,
          32'h123, 32'hBD0, 32'h1BE3, 32'h0380_1C04},
        // R4 sign extension, R8 result 2 with negative term
        '{32'h9C00, 32'h8C08, 32'h80, 32'h700, 32'h100, 32'h0, 32'h0,
          32'h80, 32'h7, 32'hFFFF_FF87, 32'h9C00},
        // R5 cross input, R6 raw add, R7 force bits
        '{32'h17C00, 32'h140C04, 32'h11, 32'h2222, 32'h1, 32'h5, 32'h10,
          32'h2223, 32'h2000_2227, 32'h2234, 32'h0301_7C00},
        // R3 empty mask, R13 flags
        '{32'h1100, 32'h0, 32'hFFFF_FFFF, 32'h3, 32'h7, 32'h0, 32'h0,
          32'h7, 32'h1, 32'h1, 32'h0380_1100}
    };

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        req_en = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_en = 1'b0; req_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        req_en = 1'b1; req_we = 1'b0; req_addr = a;
        @(negedge clk);
        req_en = 1'b0;
        d = rd_data;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic rdchk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        logic [31:0] v, held;
        repeat (3) @(negedge clk);
        chk("R1 rd_data at reset", rd_data, 32'h0);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++) rdchk("R1 reset read", 4'(a), 32'h0);

        // table walk: program, peek three results, read ctrl0
        for (int i = 0; i < 4; i++) begin
            wr(CTRL0, VECS[i].c0); wr(CTRL1, VECS[i].c1);
            wr(ACC0, VECS[i].a0);  wr(ACC1, VECS[i].a1);
            wr(BASE0, VECS[i].b0); wr(BASE1, VECS[i].b1); wr(BASE2, VECS[i].b2);
            rdchk("R3/R4/R5/R6 peek0", PEEK0, VECS[i].e0);
            rdchk("R3/R4/R6/R7 peek1", PEEK1, VECS[i].e1);
            rdchk("R8 peek2", PEEK2, VECS[i].e2);
            rdchk("R13 ctrl0 flags", CTRL0, VECS[i].ec0);
        end

        // R2: stored registers read back, write-only addresses read zero
        rdchk("R2 base2 readback", BASE2, 32'h0);
        rdchk("R2 acc1 readback", ACC1, 32'h3);
        rdchk("R2 add0 reads zero", ADD0, 32'h0);
        rdchk("R2 bpair reads zero", BPAIR, 32'h0);
        rd(ACC1, held);
        repeat (3) @(negedge clk);
        chk("R2 rd_data holds when idle", rd_data, held);

        // R9 pop write-back
        wr(CTRL0, 32'h7C00); wr(CTRL1, 32'h7C00);
        wr(ACC0, 5); wr(ACC1, 7); wr(BASE0, 1); wr(BASE1, 2); wr(BASE2, 0);
        rdchk("R9 pop0 value", POP0, 32'd6);
        rdchk("R9 acc0 after pop", ACC0, 32'd6);
        rdchk("R9 acc1 after pop", ACC1, 32'd9);
        wr(CTRL0, 32'h27C00);
        rdchk("R9 pop1 value", POP1, 32'd11);
        rdchk("R9 cross result acc0", ACC0, 32'd11);
        rdchk("R9 own result acc1", ACC1, 32'd11);
        rdchk("R9 R8 pop2 value", POP2, 32'd22);
        rdchk("R9 pop2 updates acc0", ACC0, 32'd13);
        // R7 force bits not written back
        wr(CTRL0, 32'h7C00); wr(CTRL1, 32'h187C00);
        rdchk("R9 pop0 value 2", POP0, 32'd14);
        rdchk("R7 acc1 without force bits", ACC1, 32'd15);
        rdchk("R7 peek1 with force bits", PEEK1, 32'h3000_0011);

        // R10 peek has no side effects
        rdchk("R10 peek0 first", PEEK0, 32'd15);
        rdchk("R10 peek0 second", PEEK0, 32'd15);
        rdchk("R10 acc0 unchanged", ACC0, 32'd14);
        rdchk("R10 acc1 unchanged", ACC1, 32'd15);

        // R11 atomic add
        wr(ACC0, 32'hFFFF_FFF0);
        wr(ADD0, 32'hFF00_0020);
        rdchk("R11 add0 wraps, top byte ignored", ACC0, 32'h10);
        wr(ADD1, 32'h00FF_FFFF);
        rdchk("R11 add1", ACC1, 32'h0100_000E);

        // R12 base pair
        wr(BASE2, 32'h55);
        wr(BPAIR, 32'hABCD_1234);
        rdchk("R12 base0 low half", BASE0, 32'h1234);
        rdchk("R12 base1 high half", BASE1, 32'hABCD);
        rdchk("R12 base2 kept", BASE2, 32'h55);

        // R13 unstored control bits
        wr(ACC0, 0); wr(ACC1, 0);
        wr(CTRL0, 32'hFFFF_FFFF); wr(CTRL1, 32'hFFFF_FFFF);
        rdchk("R13 ctrl0 upper bits dropped", CTRL0, 32'h001F_FFFF);
        rdchk("R13 ctrl1 upper bits dropped", CTRL1, 32'h001F_FFFF);
        // R13: lane1 overflow shows in ctrl0 only
        wr(CTRL0, 32'h7C00); wr(CTRL1, 32'h0); wr(ACC1, 32'h2);
        rdchk("R13 ctrl0 lane1 flag", CTRL0, 32'h0300_7C00);
        rdchk("R13 ctrl1 no flags", CTRL1, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule